// File: doc/BRIEF.md
# Software-Managed Translation Buffer with Victim Pointer

This block is a small fully associative address translation buffer for a device-side memory management unit. Each entry pairs a match half (virtual page number, page-size code, valid bit) with a data half (physical frame number and attribute bits). Software owns replacement. It stages a match word and a data word, points a victim index at an entry, and issues commands that load the staged words into that entry, invalidate it, or invalidate the whole buffer. The same victim index selects the entry whose contents software can read back, so software can scan for free or stale slots.

A combinational lookup port takes a 32-bit device address. It returns a hit flag, the translated physical address and the attribute bits of the matching entry. Each entry matches at one of four page sizes. When several entries cover the address, the lowest-numbered one is used.

Top module: `iotlb_victim`

## Requirements
- R1: The register map uses word offsets 0 lock, 1 staged match word, 2 staged data word, 3 load command, 4 single-invalidate command, 5 invalidate-all command, 6 read-back match word, 7 read-back data word. A command acts only when bit 0 of the written data is 1. Offsets 1 and 2 read back the last staged value, and the command offsets read 0.
- R2: In the lock register the victim index sits at bit 4 upward and the base field at bit 10 upward. The base field always reads 0, and writes to it are ignored.
- R3: A lock write whose victim value is NUM_ENTRIES or larger leaves the victim index unchanged.
- R4: A load copies the staged words into the entry named by the victim index. The match word holds the virtual page number in bits 31:12, valid in bit 2 and the size code in bits 1:0. The data word holds the frame number in bits 31:12 and the attributes in bits 3:0.
- R5: After a load the victim index advances by one and wraps to 0 after entry NUM_ENTRIES-1.
- R6: A single-invalidate clears the valid bit of the victim entry only and leaves the victim index unchanged.
- R7: An invalidate-all clears every valid bit and returns the victim index to 0.
- R8: Offsets 6 and 7 return the victim entry in the R4 layouts with all other bits 0. A cleared entry shows bit 2 as 0, and its other fields are kept.
- R9: Size code 0 means 4 KB, 1 means 64 KB, 2 means 1 MB and 3 means 16 MB. An entry hits when it is valid and its page start (the stored page number with the offset bits cleared) is at or below the address, and the address is below start plus the page size.
- R10: When more than one entry hits, the lowest index wins.
- R11: On a hit the translated address is the frame base with its offset bits cleared, combined with the address offset below the page size, and the attributes come from the same entry. On a miss the hit flag, address and attributes are 0.
- R12: A lookup reflects the contents before any command in the same cycle. The update is visible from the next cycle.
- R13: After reset every entry is invalid, and the lock register and both staged words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| lk_va_i | input | 32 | Lookup device address |
| lk_hit_o | output | 1 | Lookup hit |
| lk_pa_o | output | 32 | Translated address |
| lk_attr_o | output | 4 | Attributes of the hitting entry |

## Verification
A lookup and a table update (a load, a single invalidate or an invalidate-all) can fall in the same cycle. The bench provokes this by holding the lookup address inside the page being changed while the command strobe is high. It samples the lookup before the edge, where the old contents must be seen, and again one cycle later, where the new contents must be seen. Expected hits, translated addresses and read-back words come from a bench model that computes page ranges arithmetically.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned PN_W    = 20;
  localparam int unsigned ATTR_W  = 4;
  localparam int unsigned VICT_SH = 4;
  localparam int unsigned BASE_SH = 10;

  typedef enum logic [2:0] {
    REG_LOCK     = 3'd0,
    REG_CAM      = 3'd1,
    REG_RAM      = 3'd2,
    REG_LOAD     = 3'd3,
    REG_FLUSH1   = 3'd4,
    REG_FLUSHALL = 3'd5,
    REG_RDCAM    = 3'd6,
    REG_RDRAM    = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_64K = 2'd1,
    PG_1M  = 2'd2,
    PG_16M = 2'd3
  } pg_size_e;

  typedef struct packed {
    logic              vld;
    logic [1:0]        sz;
    logic [PN_W-1:0]   vpn;
    logic [PN_W-1:0]   pfn;
    logic [ATTR_W-1:0] attr;
  } tlb_entry_t;

  // page-number bits that are offset bits at a given size
  function automatic logic [PN_W-1:0] pn_mask(input logic [1:0] sz);
    case (pg_size_e'(sz))
      PG_64K:  pn_mask = PN_W'(20'h0000F);
      PG_1M:   pn_mask = PN_W'(20'h000FF);
      PG_16M:  pn_mask = PN_W'(20'h00FFF);
      default: pn_mask = '0;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] cam_word(input tlb_entry_t e);
    cam_word = {e.vpn, 9'b0, e.vld, e.sz};
  endfunction

  function automatic logic [ADDR_W-1:0] ram_word(input tlb_entry_t e);
    ram_word = {e.pfn, 8'b0, e.attr};
  endfunction
endpackage

// File: rtl/iotlb_regs.sv
module iotlb_regs
  import iotlb_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] cam_o,
  output logic [ADDR_W-1:0] ram_o,
  output tlb_entry_t        stage_o,
  output logic [IDX_W-1:0]  victim_o,
  output logic              load_o,
  output logic              flush_one_o,
  output logic              flush_all_o
);
  localparam logic [IDX_W:0]   N_L  = (IDX_W+1)'(N);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N-1);

  logic [ADDR_W-1:0] cam_q, ram_q;
  logic [IDX_W-1:0]  victim_q, vict_f, vict_inc;

  assign vict_f      = wdata_i[VICT_SH +: IDX_W];
  assign vict_inc    = (victim_q == LAST) ? '0 : victim_q + 1'b1;
  assign load_o      = we_i && (addr_i == REG_LOAD)     && wdata_i[0];
  assign flush_one_o = we_i && (addr_i == REG_FLUSH1)   && wdata_i[0];
  assign flush_all_o = we_i && (addr_i == REG_FLUSHALL) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      victim_q <= '0;
      cam_q    <= '0;
      ram_q    <= '0;
    end else begin
      if (we_i) begin
        case (addr_i)
          REG_LOCK: if ({1'b0, vict_f} < N_L) victim_q <= vict_f;
          REG_CAM:  cam_q <= wdata_i;
          REG_RAM:  ram_q <= wdata_i;
          default:  ;
        endcase
      end
      if (load_o)      victim_q <= vict_inc;
      if (flush_all_o) victim_q <= '0;
    end
  end

  assign cam_o    = cam_q;
  assign ram_o    = ram_q;
  assign victim_o = victim_q;
  assign stage_o  = '{vld: cam_q[2], sz: cam_q[1:0], vpn: cam_q[31:12],
                      pfn: ram_q[31:12], attr: ram_q[ATTR_W-1:0]};
endmodule

// File: rtl/iotlb_array.sv
module iotlb_array
  import iotlb_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic                   flush_one_i,
  input  logic                   flush_all_i,
  input  logic [IDX_W-1:0]       victim_i,
  input  tlb_entry_t             stage_i,
  output tlb_entry_t [N-1:0]     entries_o
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    tlb_entry_t ent_q;
    logic       sel;
    assign sel = (victim_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q <= '0;
      end else if (load_i && sel) begin
        ent_q <= stage_i;
      end else if (flush_all_i || (flush_one_i && sel)) begin
        ent_q.vld <= 1'b0;
      end
    end

    assign entries_o[g] = ent_q;
  end
endmodule

// File: rtl/iotlb_lookup.sv
module iotlb_lookup
  import iotlb_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 3
) (
  input  tlb_entry_t [N-1:0]  entries_i,
  input  logic [ADDR_W-1:0]   va_i,
  output logic                hit_o,
  output logic [ADDR_W-1:0]   pa_o,
  output logic [ATTR_W-1:0]   attr_o
);
  logic [N-1:0]     match;
  logic [IDX_W-1:0] sel;
  tlb_entry_t       e;
  logic [PN_W-1:0]  m;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = entries_i[g].vld &&
      (((va_i[31:12] ^ entries_i[g].vpn) & ~pn_mask(entries_i[g].sz)) == '0);
  end

  // lowest index wins: scan downward, last assignment sticks
  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) sel = IDX_W'(i);
    end
  end

  assign hit_o  = |match;
  assign e      = entries_i[sel];
  assign m      = pn_mask(e.sz);
  assign pa_o   = hit_o ? {(e.pfn & ~m) | (va_i[31:12] & m), va_i[11:0]} : '0;
  assign attr_o = hit_o ? e.attr : '0;
endmodule

// File: rtl/iotlb_victim.sv
module iotlb_victim
  import iotlb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [31:0]       lk_va_i,
  output logic              lk_hit_o,
  output logic [31:0]       lk_pa_o,
  output logic [3:0]        lk_attr_o
);
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  tlb_entry_t [NUM_ENTRIES-1:0] entries;
  tlb_entry_t                   stage, cur;
  logic [ADDR_W-1:0]            cam_stage, ram_stage;
  logic [IDX_W-1:0]             victim;
  logic                         load, flush_one, flush_all;

  iotlb_regs #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .cam_o(cam_stage), .ram_o(ram_stage), .stage_o(stage),
    .victim_o(victim), .load_o(load),
    .flush_one_o(flush_one), .flush_all_o(flush_all)
  );

  iotlb_array #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_array (
    .clk_i, .rst_ni,
    .load_i(load), .flush_one_i(flush_one), .flush_all_i(flush_all),
    .victim_i(victim), .stage_i(stage), .entries_o(entries)
  );

  iotlb_lookup #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_lookup (
    .entries_i(entries), .va_i(lk_va_i),
    .hit_o(lk_hit_o), .pa_o(lk_pa_o), .attr_o(lk_attr_o)
  );

  assign cur = entries[victim];

  always_comb begin
    case (reg_addr_i)
      REG_LOCK:  reg_rdata_o = 32'(victim) << VICT_SH;
      REG_CAM:   reg_rdata_o = cam_stage;
      REG_RAM:   reg_rdata_o = ram_stage;
      REG_RDCAM: reg_rdata_o = cam_word(cur);
      REG_RDRAM: reg_rdata_o = ram_word(cur);
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/iotlb_victim_chk.sv
module iotlb_victim_chk #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [2:0]       addr_i,
  input logic             cmd_i,
  input logic [IDX_W-1:0] base_rd_i,
  input logic             hit_i,
  input logic [IDX_W-1:0] victim_i
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N-1);
  localparam logic [IDX_W:0]   N_L  = (IDX_W+1)'(N);

  logic is_load, is_f1, is_fa;
  assign is_load = we_i && cmd_i && (addr_i == 3'd3);
  assign is_f1   = we_i && cmd_i && (addr_i == 3'd4);
  assign is_fa   = we_i && cmd_i && (addr_i == 3'd5);

  AST_VICT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, victim_i} < N_L); // R3

  AST_LOAD_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_load |=> victim_i == (($past(victim_i) == LAST) ? '0 : $past(victim_i) + 1'b1)); // R5

  AST_FLUSH1_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_f1 |=> $stable(victim_i)); // R6

  AST_GFLUSH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_fa |=> (!hit_i && victim_i == '0)); // R7

  AST_BASE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 3'd0) |-> base_rd_i == '0); // R2
endmodule

bind iotlb_victim iotlb_victim_chk #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
  .cmd_i(reg_wdata_i[0]), .base_rd_i(reg_rdata_o[10 +: IDX_W]),
  .hit_i(lk_hit_o), .victim_i(victim)
);

// File: tb/sim_iotlb_victim.sv
module sim_iotlb_victim;
  localparam int NE = 6;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] va = '0;
  logic        hit;
  logic [31:0] pa;
  logic [3:0]  attr;

  int checks = 0;
  int errors = 0;

  logic [31:0] cam_m [NE];
  logic [31:0] ram_m [NE];
  logic [31:0] st_cam = '0, st_ram = '0;
  int          vict_m = 0;

  always #5 clk = ~clk;

  iotlb_victim #(.NUM_ENTRIES(NE)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .lk_va_i(va),
    .lk_hit_o(hit), .lk_pa_o(pa), .lk_attr_o(attr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); we = 1'b0; addr = a; #1;
    chk(rdata === exp, req, rdata, exp);
  endtask

  task automatic exp_lk(input logic [31:0] v, output logic h, output logic [31:0] p, output logic [3:0] at);
    h = 1'b0; p = '0; at = '0;
    for (int i = NE - 1; i >= 0; i--) begin
      longint unsigned size, start, fb;
      size  = 64'd1 << (12 + 4 * int'(cam_m[i][1:0]));
      start = {32'h0, cam_m[i][31:12], 12'h0} & ~(size - 1);
      fb    = {32'h0, ram_m[i][31:12], 12'h0} & ~(size - 1);
      if (cam_m[i][2] && start <= 64'(v) && 64'(v) < start + size) begin
        h  = 1'b1;
        p  = 32'(fb | (64'(v) & (size - 1)));
        at = ram_m[i][3:0];
      end
    end
  endtask

  task automatic cmp_lk(input string req);
    logic h; logic [31:0] p; logic [3:0] at;
    exp_lk(va, h, p, at);
    chk(hit === h, req, 32'(hit), 32'(h));
    chk(pa === p && attr === at, req, pa ^ 32'(attr), p ^ 32'(at));
  endtask

  task automatic lk(input logic [31:0] v, input string req);
    @(negedge clk); va = v; #1;
    cmp_lk(req);
  endtask

  task automatic m_load();
    cam_m[vict_m] = st_cam; ram_m[vict_m] = st_ram;
    vict_m = (vict_m + 1) % NE;
  endtask

  task automatic stage(input logic [31:0] c, input logic [31:0] r);
    wr(3'd1, c); st_cam = c;
    wr(3'd2, r); st_ram = r;
  endtask

  // command with lookup held in the same cycle (R12)
  task automatic cmd_same_cycle(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk); we = 1'b1; addr = a; wdata = 32'h1; va = v; #1;
    cmp_lk("R12 before edge");
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NE; i++) begin cam_m[i] = '0; ram_m[i] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R13 reset state
    rd(3'd0, 32'h0, "R13 lock");
    rd(3'd1, 32'h0, "R13 cam stage");
    rd(3'd2, 32'h0, "R13 ram stage");
    rd(3'd6, 32'h0, "R13 rdcam");
    lk(32'h1000_0000, "R13 no hit");

    // R4 R5 fill all entries, one size per index
    for (int i = 0; i < NE; i++) begin
      logic [31:0] c, r;
      c = {20'(((i + 1) << 16)), 9'b0, 1'b1, 2'(i % 4)};
      r = {20'h80ABC + 20'(i << 12), 8'h0, 4'(i + 1)};
      stage(c, r);
      rd(3'd1, c, "R1 cam stage readback");
      rd(3'd2, r, "R1 ram stage readback");
      rd(3'd3, 32'h0, "R1 command offset reads 0");
      wr(3'd3, 32'h1); m_load();
      rd(3'd0, 32'(vict_m) << 4, "R5 victim advance/wrap");
    end

    // R9 R11 range sweep per entry
    for (int i = 0; i < NE; i++) begin
      logic [31:0] s, sz;
      s  = 32'(i + 1) << 28;
      sz = 32'd1 << (12 + 4 * (i % 4));
      lk(s, "R9 start");
      lk(s + sz - 1, "R9 last byte");
      lk(s + sz, "R9 end miss");
      lk(s - 1, "R9 below start");
      lk(s + (sz >> 1) + 32'h123, "R11 offset merge");
    end

    // R10 overlapping 1MB entry at index 0 inside 16MB entry 3
    stage({20'h40100, 9'b0, 1'b1, 2'd2}, {20'h12345, 8'h0, 4'hF});
    wr(3'd3, 32'h1); m_load();
    lk(32'h4012_3456, "R10 lowest index wins");
    lk(32'h4100_0000, "R10 other entry");

    // R4 load with valid clear into entry 1
    stage({20'h20000, 9'b0, 1'b0, 2'd1}, {20'h55555, 8'h0, 4'h3});
    wr(3'd3, 32'h1); m_load();
    lk(32'h2000_0010, "R4 invalid load misses");

    // R8 read-back sweep
    for (int k = 0; k < NE; k++) begin
      wr(3'd0, 32'(k) << 4); vict_m = k;
      rd(3'd6, cam_m[k], "R8 rdcam");
      rd(3'd7, ram_m[k], "R8 rdram");
    end

    // R3 out-of-range victim, R2 base ignored
    wr(3'd0, 32'd6 << 4);
    rd(3'd0, 32'd5 << 4, "R3 victim 6 ignored");
    wr(3'd0, 32'd7 << 4);
    rd(3'd0, 32'd5 << 4, "R3 victim 7 ignored");
    wr(3'd0, (32'd3 << 10) | (32'd2 << 4)); vict_m = 2;
    rd(3'd0, 32'd2 << 4, "R2 base reads 0");

    // R6 R12 single invalidate of entry 2 with lookup in its page
    cmd_same_cycle(3'd4, 32'h3000_0400);
    cam_m[2][2] = 1'b0;
    #1; cmp_lk("R6 R12 after flush one");
    rd(3'd0, 32'd2 << 4, "R6 victim unchanged");
    rd(3'd6, cam_m[2], "R8 R6 cleared entry readback");
    lk(32'h5000_0000, "R6 other entry kept");

    // R12 load in the same cycle as lookup
    stage({20'h70000, 9'b0, 1'b1, 2'd1}, {20'h9A000, 8'h0, 4'h6});
    cmd_same_cycle(3'd3, 32'h7000_8000);
    m_load();
    #1; cmp_lk("R12 R4 after load");
    rd(3'd0, 32'd3 << 4, "R5 advance after same-cycle load");

    // R7 R12 invalidate-all
    cmd_same_cycle(3'd5, 32'h7000_8000);
    for (int i = 0; i < NE; i++) cam_m[i][2] = 1'b0;
    vict_m = 0;
    #1; cmp_lk("R7 R12 after flush all");
    rd(3'd0, 32'h0, "R7 lock cleared");
    for (int i = 0; i < NE; i++) begin
      lk((32'(i + 1) << 28) + 32'h10, "R7 all miss");
    end
    for (int k = 0; k < NE; k++) begin
      wr(3'd0, 32'(k) << 4);
      rd(3'd6, cam_m[k], "R7 R8 invalid readback");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule